// File: doc/BRIEF.md
# Phase-Locked Multi-Ratio Clock Divider Bank

This block turns one external clock or gate signal into several divided clocks at once. The external signal is asynchronous. It is brought into the fast system clock domain and reduced to single-cycle rise and fall strobes. Every output lane counts that one shared strobe stream. Because of this, lanes with related ratios always change state on the same input edge, and rhythmic patterns taken from one master clock stay locked together.

Each lane has its own ratio from 1 to `MAX_DIV` and its own half-step flag. In whole mode a lane counts rising input edges, that is, full input cycles. In half mode it counts every edge, so a setting of N gives a ratio of N.5. For odd unit counts, the low phase takes the larger half and the high phase takes the smaller half, which keeps the duty near 50%. The high time of the input never matters.

A new ratio on a lane is loaded only when that lane finishes its current period. This avoids short pulses when a control is moved while the lane is running.

Top module: `clkdiv_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every lane's counter clears and every output is low after that edge, and each lane loads its ratio and half flag from the ports.
- R2: The input is passed through a two-flop synchronizer before edge detection, and counting depends only on detected edges. The high or low time of the input (one system cycle or more) has no effect on any output.
- R3: In whole mode with ratio N ≥ 2, let k be the number of rising input edges since reset. The output is high exactly when (k mod N) ≥ ceil(N/2). So the output is low for ceil(N/2) input cycles, then high for floor(N/2) (divide-by-7: 4 low, then 3 high).
- R4: All lanes advance on the same strobes. Lanes set to 2, 4 and 8 are all high after the 7th rising edge and all fall on the 8th.
- R5: In half mode with ratio N ≥ 2, let e be the number of input edges of either polarity since reset. The output is high exactly when (e mod (2N+1)) ≥ N+1 (7.5: 8 half-cycles low, then 7 high).
- R6: A lane with ratio 1 follows the synchronized input level, and its half flag has no effect.
- R7: When no input edge arrives, every output holds its level. Counting resumes from the held count on the next edge.
- R8: A ratio or half flag written while a lane is running takes effect only after the lane completes its current period. For a ratio-1 lane, the period ends on an input falling edge.
- R9: A ratio field of 0 acts as 1. A ratio field above `MAX_DIV` acts as `MAX_DIV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous input clock or gate |
| div_sel | input | NUM_OUT*4 | Ratio field per lane; lane i uses bits [4i+3:4i] |
| half_sel | input | NUM_OUT | Half-step flag per lane; bit i for lane i |
| div_out | output | NUM_OUT | Divided outputs, bit i for lane i |

## Verification
A lane's period wrap can happen in the same cycle as the loading of a new ratio. In that cycle the counter returns to zero, the output falls, and the new settings are taken in, all on the same strobe. The bench provokes this by changing a lane from 4 to 2 after the first rising edge. It then checks that the old period of 4 finishes exactly on the 4th edge and that divide-by-2 timing follows from the 5th edge on. The bench also checks that a rise and a fall of several lanes fall on the same edge, by reading the /2, /4 and /8 lanes together on the 7th and 8th edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned DIV_W = 4;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic             half;
    } lane_cfg_t;

    function automatic logic [DIV_W-1:0] clamp_ratio(
        input logic [DIV_W-1:0] raw,
        input logic [DIV_W-1:0] top
    );
        if (raw == '0)
            return DIV_W'(1);
        else if (raw > top)
            return top;
        else
            return raw;
    endfunction

    // length of one output period in counted units
    function automatic int unsigned period_units(input lane_cfg_t c);
        if (c.half)
            return 2 * int'(c.ratio) + 1;
        else
            return int'(c.ratio);
    endfunction

    // count at which the output rises; low phase takes the larger share
    function automatic int unsigned rise_units(input lane_cfg_t c);
        return (period_units(c) + 1) / 2;
    endfunction

endpackage

// File: rtl/clkdiv_edge_sync.sv
module clkdiv_edge_sync
    import clkdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  async_in,
    output edge_t strobe,
    output logic  level
);
    logic meta_q, stable_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
            last_q   <= stable_q;
        end
    end

    always_comb begin
        strobe.rise = stable_q & ~last_q;
        strobe.fall = ~stable_q & last_q;
    end

    assign level = stable_q;

    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (rst)
        !(strobe.rise && strobe.fall));                                 // R2
    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        strobe.rise |=> !strobe.rise);                                  // R2

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
    import clkdiv_pkg::*;
#(
    parameter int unsigned MAX_DIV = 8,
    parameter int unsigned CNT_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  edge_t                strobe,
    input  logic [DIV_W-1:0]     ratio_in,
    input  logic                 half_in,
    output logic                 lane_out
);
    lane_cfg_t        cfg_q, cfg_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_unit, high_at;
    logic             pass, adv, out_q;

    always_comb begin
        cfg_next.ratio = clamp_ratio(ratio_in, DIV_W'(MAX_DIV));
        cfg_next.half  = half_in;
        pass           = (cfg_q.ratio == DIV_W'(1));
        adv            = cfg_q.half ? (strobe.rise | strobe.fall) : strobe.rise;
        last_unit      = CNT_W'(period_units(cfg_q) - 1);
        high_at        = CNT_W'(rise_units(cfg_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_next;
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (pass) begin
            if (strobe.rise) begin
                out_q <= 1'b1;
            end else if (strobe.fall) begin
                out_q <= 1'b0;
                cnt_q <= '0;
                cfg_q <= cfg_next;
            end
        end else if (adv) begin
            if (cnt_q == last_unit) begin
                cnt_q <= '0;
                out_q <= 1'b0;
                cfg_q <= cfg_next;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q + 1'b1 == high_at)
                    out_q <= 1'b1;
            end
        end
    end

    assign lane_out = out_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(strobe.rise || strobe.fall) |=> $stable(out_q));              // R7
    AST_PHASE_SPLIT: assert property (@(posedge clk) disable iff (rst)
        !pass |-> (out_q == (cnt_q >= high_at)));                       // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        !pass |-> (cnt_q <= last_unit));                                // R5
    AST_PASS_RISE: assert property (@(posedge clk) disable iff (rst)
        (pass && strobe.rise) |=> out_q);                               // R6
    AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> (cnt_q == '0 && !out_q));                   // R8
    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ratio != '0) && (int'(cfg_q.ratio) <= MAX_DIV));         // R9

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_OUT = 4,
    parameter int unsigned MAX_DIV = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pulse_in,
    input  logic [NUM_OUT*DIV_W-1:0] div_sel,
    input  logic [NUM_OUT-1:0]       half_sel,
    output logic [NUM_OUT-1:0]       div_out
);
    localparam int unsigned CNT_W = $clog2(2 * MAX_DIV + 2);

    edge_t strobe;
    logic  level_unused;

    clkdiv_edge_sync i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pulse_in),
        .strobe   (strobe),
        .level    (level_unused)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        clkdiv_lane #(
            .MAX_DIV (MAX_DIV),
            .CNT_W   (CNT_W)
        ) i_lane (
            .clk      (clk),
            .rst      (rst),
            .strobe   (strobe),
            .ratio_in (div_sel[g*DIV_W +: DIV_W]),
            .half_in  (half_sel[g]),
            .lane_out (div_out[g])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (div_out == '0));                                       // R1

endmodule

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N_OUT      = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pulse_in = 1'b0;
    logic [N_OUT*4-1:0] div_sel = '0;
    logic [N_OUT-1:0] half_sel = '0;
    logic [N_OUT-1:0] div_out;

    int total = 0;
    int bad   = 0;

    clkdiv_bank #(.NUM_OUT(N_OUT), .MAX_DIV(8)) i_clkdiv_bank (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .div_sel  (div_sel),
        .half_sel (half_sel),
        .div_out  (div_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
        end
    endtask

    function automatic logic whole_exp(input int n, input int k);
        return (k % n) >= (n + 1) / 2;
    endfunction

    function automatic logic half_exp(input int n, input int e);
        return (e % (2 * n + 1)) >= (n + 1);
    endfunction

    task automatic setup(input logic [3:0] d0, input logic [3:0] d1,
                         input logic [3:0] d2, input logic [3:0] d3,
                         input logic [3:0] h);
        div_sel  = {d3, d2, d1, d0};
        half_sel = h;
        pulse_in = 1'b0;
        rst      = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
    endtask

    // one input cycle: high for hw system cycles, then low and settle
    task automatic in_cycle(input int hw);
        pulse_in = 1'b1;
        tick(hw);
        pulse_in = 1'b0;
        tick(4);
    endtask

    task automatic t_reset;
        setup(4'd2, 4'd3, 4'd4, 4'd7, 4'b0000);
        for (int i = 0; i < N_OUT; i++) check(div_out[i], 1'b0, "R1 reset low");
    endtask

    task automatic t_whole_mixed;
        setup(4'd2, 4'd3, 4'd4, 4'd7, 4'b0000);
        for (int k = 1; k <= 28; k++) begin
            in_cycle(1 + (k % 5));           // R2 varying high time
            check(div_out[0], whole_exp(2, k), "R3 div2");
            check(div_out[1], whole_exp(3, k), "R3 div3");
            check(div_out[2], whole_exp(4, k), "R3 div4");
            check(div_out[3], whole_exp(7, k), "R3 div7 / R2 width");
        end
    endtask

    task automatic t_lockstep;
        setup(4'd2, 4'd4, 4'd8, 4'd6, 4'b0000);
        for (int k = 1; k <= 24; k++) begin
            in_cycle(2);
            if (k == 7) begin
                check(div_out[0], 1'b1, "R4 div2 high at 7");
                check(div_out[1], 1'b1, "R4 div4 high at 7");
                check(div_out[2], 1'b1, "R4 div8 high at 7");
            end else if (k == 8) begin
                check(div_out[0], 1'b0, "R4 div2 falls at 8");
                check(div_out[1], 1'b0, "R4 div4 falls at 8");
                check(div_out[2], 1'b0, "R4 div8 falls at 8");
            end
            check(div_out[3], whole_exp(6, k), "R4 div6");
            check(div_out[2], whole_exp(8, k), "R3 div8");
        end
    endtask

    task automatic t_half;
        int e = 0;
        int k = 0;
        // lane0 7.5, lane1 ratio1 with half set, lane2 2.5, lane3 whole 3
        setup(4'd7, 4'd1, 4'd2, 4'd3, 4'b0111);
        for (int c = 0; c < 20; c++) begin
            pulse_in = 1'b1;
            tick(4);
            e++; k++;
            check(div_out[0], half_exp(7, e), "R5 7.5 after rise");
            check(div_out[1], 1'b1,           "R6 pass high");
            check(div_out[2], half_exp(2, e), "R5 2.5 after rise");
            check(div_out[3], whole_exp(3, k), "R3 whole beside half");
            pulse_in = 1'b0;
            tick(4);
            e++;
            check(div_out[0], half_exp(7, e), "R5 7.5 after fall");
            check(div_out[1], 1'b0,           "R6 pass low");
            check(div_out[2], half_exp(2, e), "R5 2.5 after fall");
            check(div_out[3], whole_exp(3, k), "R3 whole ignores fall");
        end
    endtask

    task automatic t_change;
        logic exp_seq [2:6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
        setup(4'd4, 4'd4, 4'd4, 4'd4, 4'b0000);
        in_cycle(2);
        check(div_out[0], 1'b0, "R8 first edge");
        div_sel[3:0] = 4'd2;
        for (int k = 2; k <= 6; k++) begin
            in_cycle(2);
            check(div_out[0], exp_seq[k], "R8 old period then new ratio");
            check(div_out[1], whole_exp(4, k), "R8 other lane unaffected");
        end
    endtask

    task automatic t_hold;
        logic [N_OUT-1:0] snap;
        setup(4'd3, 4'd5, 4'd6, 4'd8, 4'b0000);
        for (int k = 1; k <= 4; k++) in_cycle(3);
        snap = div_out;
        check(div_out[1], whole_exp(5, 4), "R7 before idle");
        tick(300);
        for (int i = 0; i < N_OUT; i++) check(div_out[i], snap[i], "R7 hold idle");
        for (int k = 5; k <= 12; k++) begin
            in_cycle(3);
            check(div_out[0], whole_exp(3, k), "R7 resume div3");
            check(div_out[1], whole_exp(5, k), "R7 resume div5");
            check(div_out[3], whole_exp(8, k), "R7 resume div8");
        end
        rst = 1'b1;
        tick(2);
        for (int i = 0; i < N_OUT; i++) check(div_out[i], 1'b0, "R1 reset mid-run");
        rst = 1'b0;
        tick(2);
    endtask

    task automatic t_clamp;
        // ratio 0 acts as 1, ratio 15 acts as 8
        setup(4'd0, 4'd15, 4'd5, 4'd1, 4'b0000);
        for (int k = 1; k <= 16; k++) begin
            pulse_in = 1'b1;
            tick(4);
            check(div_out[0], 1'b1, "R9 zero acts as pass high");
            check(div_out[3], 1'b1, "R6 ratio1 high");
            pulse_in = 1'b0;
            tick(4);
            check(div_out[0], 1'b0, "R9 zero acts as pass low");
            check(div_out[1], whole_exp(8, k), "R9 over-range acts as 8");
            check(div_out[2], whole_exp(5, k), "R3 div5");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_whole_mixed();
        t_lockstep();
        t_half();
        t_change();
        t_hold();
        t_clamp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule